// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects nine maskable peripheral interrupt sources, a reset-entry request and a software break request. It tells the CPU whether an interrupt is waiting and gives it a 16-bit vector address for the winning source. Each maskable source has a request bit and an enable bit. Software can clear request bits but cannot set them. A global disable flag I masks all nine maskable sources. The reset-entry and break requests ignore every mask.

When the CPU acknowledges, the block latches the vector of the current winner. The vector then stays stable for the whole fetch. On the same acknowledge the block sets I and clears the serviced request bit. The vector output gives the address of the low byte of the vector, and the high byte sits at that address plus one.

Software reaches the request bits, the enable bits and I through a small register port. Writes use a 2-bit address and an 8-bit data bus. Reads are combinational.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all request and enable bits are 0, I is 1, a reset-entry request is pending, and `vec_addr` reads 16'hFFFE.
- R2: The priority runs from highest to lowest as follows: reset-entry, then maskable sources 0 through 8 in index order, then break. Index order is INT0=0, INT1/wake=1, counter=2, timer1..timer4=3..6, serial=7, A-D=8.
- R3: A source at priority level L gets the vector 16'hFFFE - 2*L. Reset-entry is L=0 (FFFE), source i is L=i+1, and break is L=10 (FFEA). The high byte lies at the vector plus 1.
- R4: A maskable source makes `irq_pend` high only when its request bit is 1, its enable bit is 1 and I is 0.
- R5: On `ack` with `irq_pend` high, the winner's vector is loaded into `vec_addr` at that edge, I becomes 1, and the winner's request bit is cleared. `vec_addr` holds its value until the next accepted `ack`.
- R6: A pulse on `src_pulse[i]` sets request bit i. A write to a request register sets each request bit to the old bit AND the written bit, so writing a 1 never sets a request. Address 0 holds requests 7:0, and bit 0 of address 1 holds request 8.
- R7: If a request is set by a pulse in the same cycle that a software write or an acknowledge clears it, the request ends up set.
- R8: The break request (`brk_req` high) makes `irq_pend` high whatever I and the enable bits hold. It has no request or enable bit, and it wins only when nothing else is pending.
- R9: Enable bits and I can be both read and written. Address 2 holds enables 7:0. Address 3 holds enable 8 in bit 0 and I in bit 7. Unused bits read as 0.
- R10: An `ack` while `irq_pend` is low changes neither `vec_addr` nor I.
- R11: The reset-entry request wins even with I at 1, and the first accepted `ack` consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 9 | One-cycle set pulses from the maskable sources |
| brk_req | input | 1 | Software break request (level) |
| ack | input | 1 | CPU acknowledges the pending interrupt |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| irq_pend | output | 1 | An interrupt is ready to be taken |
| vec_addr | output | 16 | Low-byte vector address of the last accepted interrupt |

## Verification
Request, enable and flag state changes at the clock edge that samples a pulse, a write or an acknowledge. Because `irq_pend` and `rdata` are decoded combinationally from that state, their new values are due one edge after the stimulus. `vec_addr` changes at the acknowledge edge itself. The bench drives every input on the falling edge and reads the outputs after the next rising edge, at the following falling edge, so each check sees exactly one state update.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 9,
  parameter int AW   = 2,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            brk_req,
  input  logic            ack,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_pend,
  output logic [15:0]     vec_addr
);
  localparam int LW      = $clog2(NSRC + 2);
  localparam int HI_W    = NSRC - DW;
  localparam logic [LW-1:0] BRK_LVL = LW'(NSRC + 1);

  logic [NSRC-1:0] req, en, live, keep;
  logic            iflag, rst_pend;
  logic [LW-1:0]   lvl;

  assign live     = req & en & {NSRC{~iflag}};
  assign irq_pend = rst_pend | (|live) | brk_req;
  wire   take     = ack & irq_pend;

  always_comb begin
    lvl = BRK_LVL;
    for (int i = NSRC - 1; i >= 0; i--)
      if (live[i]) lvl = LW'(i + 1);
    if (rst_pend) lvl = '0;
  end

  always_comb begin
    keep = '1;
    if (wr_en && addr == AW'(0)) keep[DW-1:0] = keep[DW-1:0] & wdata;
    if (wr_en && addr == AW'(1)) keep[NSRC-1:DW] = keep[NSRC-1:DW] & wdata[HI_W-1:0];
    for (int i = 0; i < NSRC; i++)
      if (take && lvl == LW'(i + 1)) keep[i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= '0;
      en       <= '0;
      iflag    <= 1'b1;
      rst_pend <= 1'b1;
      vec_addr <= 16'hFFFE;
    end else begin
      req <= (req & keep) | src_pulse;
      if (wr_en && addr == AW'(2)) en[DW-1:0] <= wdata;
      if (wr_en && addr == AW'(3)) begin
        en[NSRC-1:DW] <= wdata[HI_W-1:0];
        iflag         <= wdata[DW-1];
      end
      if (take) begin
        iflag    <= 1'b1;
        rst_pend <= 1'b0;
        vec_addr <= 16'hFFFE - {11'd0, lvl, 1'b0};
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(0): rdata = req[DW-1:0];
      AW'(1): rdata[HI_W-1:0] = req[NSRC-1:DW];
      AW'(2): rdata = en[DW-1:0];
      default: begin
        rdata[HI_W-1:0] = en[NSRC-1:DW];
        rdata[DW-1]     = iflag;
      end
    endcase
  end

  AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> iflag); // R5
  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(vec_addr)); // R5
  AST_RESET_ENTRY_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> irq_pend); // R11
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (iflag && !rst_pend && !brk_req) |-> !irq_pend); // R4
  AST_BRK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> irq_pend); // R8
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse == '0) |=> ((req & ~$past(req)) == '0)); // R6
  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((req & $past(src_pulse)) == $past(src_pulse))); // R7
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_pend && !wr_en) |=> ($stable(iflag) && $stable(vec_addr))); // R10
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_pulse = '0;
  logic        brk_req = 1'b0, ack = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_pend;
  logic [15:0] vec_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .brk_req(brk_req),
    .ack(ack), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_pend(irq_pend), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [8:0] m);
    @(negedge clk); src_pulse = m;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic logic [15:0] vec_of(input int l);
    return 16'hFFFE - 16'(2 * l);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg after reset", {8'd0, d}, (a == 3) ? 16'h0080 : 16'h0000);
    end
    chk("R1 reset entry pending", {15'd0, irq_pend}, 16'd1);
    chk("R1 vec after reset", vec_addr, 16'hFFFE);
    do_ack();
    chk("R11 reset vector taken", vec_addr, vec_of(0));
    chk("R11 reset entry consumed", {15'd0, irq_pend}, 16'd0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(2'd2, 8'hA5); rd(2'd2, d);
    chk("R9 enable low readback", {8'd0, d}, 16'h00A5);
    wr(2'd3, 8'hFF); rd(2'd3, d);
    chk("R9 enable high and I readback", {8'd0, d}, 16'h0081);
    wr(2'd2, 8'hFF); wr(2'd3, 8'h01); rd(2'd3, d);
    chk("R9 I cleared by write", {8'd0, d}, 16'h0001);
  endtask

  task automatic t_mask();
    chk("R4 idle no pend", {15'd0, irq_pend}, 16'd0);
    pulse(9'h008);
    chk("R4 enabled request pends", {15'd0, irq_pend}, 16'd1);
    wr(2'd3, 8'h81);
    chk("R4 I masks", {15'd0, irq_pend}, 16'd0);
    wr(2'd3, 8'h01); wr(2'd2, 8'hF7);
    chk("R4 enable bit masks", {15'd0, irq_pend}, 16'd0);
    wr(2'd2, 8'hFF);
    chk("R4 re-enabled pends", {15'd0, irq_pend}, 16'd1);
    wr(2'd0, 8'h00);
    chk("R6 software clear drops pend", {15'd0, irq_pend}, 16'd0);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    pulse(9'h124);
    do_ack();
    chk("R2 R3 source2 wins", vec_addr, vec_of(3));
    rd(2'd0, d);
    chk("R5 winner request cleared", {8'd0, d}, 16'h0020);
    rd(2'd3, d);
    chk("R5 ack sets I", {8'd0, d}, 16'h0081);
    chk("R5 no pend with I set", {15'd0, irq_pend}, 16'd0);
    wr(2'd3, 8'h01); do_ack();
    chk("R2 R3 source5 next", vec_addr, vec_of(6));
    wr(2'd3, 8'h01); do_ack();
    chk("R2 R3 source8 last", vec_addr, vec_of(9));
    rd(2'd1, d);
    chk("R5 request8 cleared", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_swclear();
    logic [7:0] d;
    wr(2'd3, 8'h80);
    pulse(9'h003);
    wr(2'd0, 8'hFE); rd(2'd0, d);
    chk("R6 clear bit0 only", {8'd0, d}, 16'h0002);
    wr(2'd0, 8'hFF); rd(2'd0, d);
    chk("R6 writing ones sets nothing", {8'd0, d}, 16'h0002);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h00; src_pulse = 9'h001;
    @(negedge clk); wr_en = 1'b0; src_pulse = '0;
    rd(2'd0, d);
    chk("R7 pulse beats software clear", {8'd0, d}, 16'h0001);
    wr(2'd0, 8'h00);
    pulse(9'h100);
    wr(2'd3, 8'h01);
    @(negedge clk); ack = 1'b1; src_pulse = 9'h100;
    @(negedge clk); ack = 1'b0; src_pulse = '0;
    chk("R7 ack vector source8", vec_addr, vec_of(9));
    rd(2'd1, d);
    chk("R7 pulse beats ack clear", {8'd0, d}, 16'h0001);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_break();
    wr(2'd3, 8'h81);
    @(negedge clk); brk_req = 1'b1;
    #1 chk("R8 break pends under I", {15'd0, irq_pend}, 16'd1);
    do_ack();
    chk("R8 R3 break vector", vec_addr, vec_of(10));
    wr(2'd3, 8'h01);
    pulse(9'h040);
    do_ack();
    chk("R8 maskable beats break", vec_addr, vec_of(7));
    @(negedge clk); brk_req = 1'b0;
  endtask

  task automatic t_idle_ack();
    logic [7:0] d;
    wr(2'd3, 8'h01);
    chk("R10 nothing pending", {15'd0, irq_pend}, 16'd0);
    do_ack();
    chk("R10 vector unchanged", vec_addr, vec_of(7));
    rd(2'd3, d);
    chk("R10 I unchanged", {8'd0, d}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_mask();
    t_priority();
    t_swclear();
    t_break();
    t_idle_ack();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule